// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single idle-high input line. The line is timed by an oversampling tick that pulses sixteen times per bit period. A falling edge on the line opens a character. The receiver checks halfway through the start bit that the line is still low; if it is not, the attempt is dropped without any error. Each data bit, and then the stop bit, is resolved by a two-out-of-three vote over samples taken around the bit centre. Bits arrive least significant first.

A finished character is 8 or 9 bits wide, chosen by a mode input, and carries a framing-error flag that is set when the stop bit reads low. It enters a two-entry queue. The oldest entry is shown on the head outputs and is removed by a read strobe. If a character completes while both entries are still unread, it is discarded and an overrun flag rises. From then on nothing more is received until an overrun-clear pulse arrives. Baud-rate generation is done outside the block, which supplies the tick.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `data_avail` and `overrun` are 0.
- R2: A frame consists of a low start bit, the data bits least significant first, and a high stop bit, each lasting 16 ticks. In 8-bit mode (`nine_bit`=0), `head_data[7:0]` holds the received byte and `head_data[8]` is 0.
- R3: In 9-bit mode (`nine_bit`=1), all nine bits of `head_data` hold the received character.
- R4: If the line is high at tick 8 after the falling edge, the receiver drops the attempt silently and queues nothing.
- R5: Each data bit and the stop bit take the majority of the line samples at ticks 7, 8 and 9 of that bit, so a single-sample glitch at the bit centre does not alter the value.
- R6: A low stop bit sets `head_ferr` to 1 for that character, and the data bits are still stored. A high stop bit stores `head_ferr` as 0.
- R7: `data_avail` is 1 while the queue holds an unread character. A `rd_pop` pulse removes the oldest entry, entries leave in arrival order, and `data_avail` falls only after a pop empties the queue.
- R8: A character that completes while two unread entries are held is discarded and sets `overrun`. The queued entries stay unchanged, and later frames are ignored while `overrun` is 1.
- R9: An `ovr_clr` pulse drops `overrun` to 0, and the next frame is received normally.
- R10: While `rx_en` is 0, frames on the line queue nothing.
- R11: Reception stays correct when ticks arrive less often than once per clock, for example every third clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input, idle high, asynchronous to clk |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1 selects 9 data bits per character, 0 selects 8 |
| os_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| rd_pop | input | 1 | Removes the oldest queued character |
| ovr_clr | input | 1 | Clears the overrun condition |
| head_data | output | 9 | Data of the oldest queued character |
| head_ferr | output | 1 | Framing-error flag of the oldest queued character |
| data_avail | output | 1 | At least one unread character is queued |
| overrun | output | 1 | A character was lost while the queue was full |

## Verification
A character enters the queue at tick 9 of its stop bit. That point lies two synchronizer clocks plus one edge-detect clock past the line transitions the bench drives, so it falls inside the stop bit. The bench therefore drives each bit for a whole bit period and then holds the line idle for one more bit period before it samples the head outputs. A pop or an overrun clear takes effect on the next clock, so those results are sampled on the falling clock edge that follows the pulse. Glitch stimulus is placed at the clock whose synchronised value becomes the middle vote sample. A false start returns high well before tick 8.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    localparam int CHAR_W  = 9;
    localparam int OS_RATE = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic              ferr;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s,
    output logic line_fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign line_s    = chain[STAGES-1];
    assign line_fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_os_rx_pkg::*;
#(
    parameter int OSR    = OS_RATE,
    parameter int DATA_W = CHAR_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     nine_bit,
    input  logic     tick,
    input  logic     line_s,
    input  logic     line_fall,
    output logic     done,
    output rx_char_t char_out
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(DATA_W);
    localparam logic [CW-1:0] MID = CW'(OSR / 2);
    localparam logic [CW-1:0] SA  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] SB  = CW'(OSR / 2 + 1);

    rx_state_e           state;
    logic [CW-1:0]       cnt;
    logic [CW-1:0]       cnt_n;
    logic [BW-1:0]       bitn;
    logic [BW-1:0]       last_bit;
    logic [DATA_W-1:0]   shreg;
    logic                s_a, s_b, maj;

    assign cnt_n    = cnt + 1'b1;
    assign last_bit = nine_bit ? BW'(DATA_W - 1) : BW'(DATA_W - 2);
    assign maj      = vote3(s_a, s_b, line_s);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            s_a      <= 1'b1;
            s_b      <= 1'b1;
            done     <= 1'b0;
            char_out <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (line_fall) state <= ST_START;
                end
                ST_START: if (tick) begin
                    cnt <= cnt_n;
                    if (cnt_n == MID && line_s) begin
                        state <= ST_IDLE;
                    end else if (cnt_n == '0) begin
                        state <= ST_DATA;
                        bitn  <= '0;
                    end
                end
                ST_DATA: if (tick) begin
                    cnt <= cnt_n;
                    if (cnt_n == SA) s_a <= line_s;
                    if (cnt_n == MID) s_b <= line_s;
                    if (cnt_n == SB) shreg <= {maj, shreg[DATA_W-1:1]};
                    if (cnt_n == '0) begin
                        if (bitn == last_bit) state <= ST_STOP;
                        else bitn <= bitn + 1'b1;
                    end
                end
                ST_STOP: if (tick) begin
                    cnt <= cnt_n;
                    if (cnt_n == SA) s_a <= line_s;
                    if (cnt_n == MID) s_b <= line_s;
                    if (cnt_n == SB) begin
                        done          <= 1'b1;
                        char_out.ferr <= ~maj;
                        char_out.data <= nine_bit ? shreg : {1'b0, shreg[DATA_W-1:1]};
                        state         <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: a stopped receiver sits idle on the next cycle
    assert_idle_when_stopped_R10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (state == ST_IDLE && !done));

    // R2: a character is delivered only out of the stop-bit phase
    assert_done_from_stop_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state) == ST_STOP);
endmodule

// File: rtl/rx_fifo2.sv
module rx_fifo2
    import uart_os_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_char_t wdata,
    input  logic     pop,
    output rx_char_t head,
    output logic     full,
    output logic     nonempty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    rx_char_t      mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [NW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wp] <= wdata;
                wp      <= bump(wp);
            end
            if (pop) rp <= bump(rp);
            count <= count + NW'(push) - NW'(pop);
        end
    end

    assign head     = mem[rp];
    assign full     = (count == NW'(DEPTH));
    assign nonempty = (count != '0);

    // R8: the queue is never written past capacity
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (push && full) |-> pop);

    // R7: the available flag only drops after a pop
    assert_avail_drop_on_pop_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(nonempty) |-> $past(pop));

    always_comb begin
        if (!rst) assert_count_bound_R7: assert (count <= NW'(DEPTH));
    end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int OSR        = OS_RATE,
    parameter int DATA_W     = CHAR_W,
    parameter int FIFO_DEPTH = 2,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              os_tick,
    input  logic              rd_pop,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] head_data,
    output logic              head_ferr,
    output logic              data_avail,
    output logic              overrun
);
    logic     line_s, line_fall;
    logic     run, done, full, pop, push, ovr_q;
    rx_char_t rx_char, head;

    rx_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .line_in(rx_line),
        .line_s(line_s), .line_fall(line_fall)
    );

    assign run = rx_en & ~ovr_q & ~ovr_clr;

    rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst(rst), .run(run), .nine_bit(nine_bit),
        .tick(os_tick), .line_s(line_s), .line_fall(line_fall),
        .done(done), .char_out(rx_char)
    );

    assign pop  = rd_pop & data_avail;
    assign push = done & (~full | pop);

    rx_fifo2 #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(rx_char), .pop(pop),
        .head(head), .full(full), .nonempty(data_avail)
    );

    always_ff @(posedge clk) begin
        if (rst || ovr_clr) ovr_q <= 1'b0;
        else if (done && full && !pop) ovr_q <= 1'b1;
    end

    assign overrun   = ovr_q;
    assign head_data = head.data;
    assign head_ferr = head.ferr;

    // R8: nothing enters the queue while overrun is pending
    assert_no_push_in_overrun_R8: assert property (@(posedge clk) disable iff (rst)
        overrun |-> !push);

    // R9: the clear pulse releases overrun on the following cycle
    assert_clear_releases_R9: assert property (@(posedge clk) disable iff (rst)
        ovr_clr |=> !overrun);
endmodule

// File: tb/uart_os_rx_tb.sv
`timescale 1ns/1ps
module uart_os_rx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       rx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       os_tick;
    logic       rd_pop = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [8:0] head_data;
    logic       head_ferr, data_avail, overrun;

    int n_vec = 0;
    int n_bad = 0;
    int div   = 1;
    int tcnt  = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    uart_os_rx u_dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .rx_en(rx_en),
        .nine_bit(nine_bit), .os_tick(os_tick), .rd_pop(rd_pop),
        .ovr_clr(ovr_clr), .head_data(head_data), .head_ferr(head_ferr),
        .data_avail(data_avail), .overrun(overrun)
    );

    initial begin
        os_tick = 1'b1;
        forever begin
            @(negedge clk);
            tcnt    = (tcnt + 1 >= div) ? 0 : tcnt + 1;
            os_tick = (tcnt == 0);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // one frame: start, data LSB first, stop; glitch inverts one clock at the middle vote sample
    task automatic send(input logic [8:0] d, input bit nine, input bit stop_v, input int glitch_bit);
        int nb = nine ? 9 : 8;
        for (int j = 0; j < nb + 2; j++) begin
            logic v = (j == 0) ? 1'b0 : (j == nb + 1) ? stop_v : d[j-1];
            for (int c = 0; c < 16 * div; c++) begin
                rx_line = (j == glitch_bit && c == 8) ? ~v : v;
                @(negedge clk);
            end
        end
        rx_line = 1'b1;
        repeat (16 * div) @(negedge clk);
    endtask

    task automatic pop1();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "data_avail after reset", data_avail, 0);
        chk("R1", "overrun after reset", overrun, 0);
    endtask

    task automatic t_byte();
        nine_bit = 1'b0;
        send(9'h0A5, 0, 1, -1);
        chk("R2", "avail after byte", data_avail, 1);
        chk("R2", "byte data", head_data, 9'h0A5);
        chk("R6", "ferr clean stop", head_ferr, 0);
        pop1();
        chk("R7", "avail after pop", data_avail, 0);
        send(9'h03C, 0, 1, -1);
        chk("R2", "second byte pattern", head_data, 9'h03C);
        pop1();
    endtask

    task automatic t_nine();
        nine_bit = 1'b1;
        send(9'h1C3, 1, 1, -1);
        chk("R3", "nine-bit data", head_data, 9'h1C3);
        pop1();
        nine_bit = 1'b0;
    endtask

    task automatic t_ferr();
        send(9'h05A, 0, 0, -1);
        chk("R6", "ferr on low stop", head_ferr, 1);
        chk("R6", "data kept with ferr", head_data, 9'h05A);
        pop1();
    endtask

    task automatic t_false_start();
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (48) @(negedge clk);
        chk("R4", "nothing after false start", data_avail, 0);
        chk("R4", "no overrun after false start", overrun, 0);
        send(9'h081, 0, 1, -1);
        chk("R4", "clean frame after false start", head_data, 9'h081);
        pop1();
    endtask

    task automatic t_glitch();
        send(9'h055, 0, 1, 4);
        chk("R5", "glitch in data bit", head_data, 9'h055);
        pop1();
        send(9'h0F0, 0, 1, 9);
        chk("R5", "glitch in stop bit ferr", head_ferr, 0);
        chk("R5", "glitch in stop bit data", head_data, 9'h0F0);
        pop1();
    endtask

    task automatic t_order_overrun();
        send(9'h011, 0, 1, -1);
        send(9'h022, 0, 1, -1);
        chk("R7", "two queued no overrun", overrun, 0);
        send(9'h033, 0, 1, -1);
        chk("R8", "overrun on third", overrun, 1);
        chk("R8", "head kept on overrun", head_data, 9'h011);
        send(9'h044, 0, 1, -1);
        chk("R8", "still head after ignored frame", head_data, 9'h011);
        pop1();
        chk("R7", "second in order", head_data, 9'h022);
        pop1();
        chk("R8", "lost frames not queued", data_avail, 0);
        chk("R8", "overrun held", overrun, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R9", "overrun cleared", overrun, 0);
        send(9'h066, 0, 1, -1);
        chk("R9", "receive after clear", head_data, 9'h066);
        chk("R9", "avail after clear", data_avail, 1);
        pop1();
    endtask

    task automatic t_disable();
        rx_en = 1'b0;
        send(9'h0C7, 0, 1, -1);
        chk("R10", "disabled queues nothing", data_avail, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_slow_tick();
        div = 3;
        repeat (6) @(negedge clk);
        send(9'h09E, 0, 1, -1);
        chk("R11", "slow tick data", head_data, 9'h09E);
        chk("R11", "slow tick avail", data_avail, 1);
        pop1();
        div = 1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        t_byte();
        t_nine();
        t_ferr();
        t_false_start();
        t_glitch();
        t_order_overrun();
        t_disable();
        t_slow_tick();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule